// File: doc/BRIEF.md
# Power-up Banner Transmitter

This block sends a fixed text banner over an asynchronous serial line once reset is released. A sequencer steps through a constant table of byte codes and hands each byte to a one-entry holding buffer through a write strobe, guarded by the buffer's full flag. A shifter empties the buffer into 8N1 frames at 115200 baud, timed from a 16.6 MHz system clock. Everything runs on that one clock, and the strobe is only ever used as a synchronous enable.

The built-in banner is the eight characters `READY v1` followed by carriage return (0x0D) and line feed (0x0A), ten bytes in all. After reset the line is held at mark for a guard interval, so a receiver that has just woken up sees a clean idle line before the first start bit. The first character is therefore received like every other one. The start-message enable lets the surrounding logic hold the banner back, or pause it part way through. The done flag reports that the last stop bit has left the pin.

Top module: `banner_tx`

## Requirements
- R1: Each character goes out as a frame of a low start bit, eight data bits with the least significant bit first, and a high stop bit. There is no parity bit.
- R2: Every bit lasts CLK_HZ/BAUD rounded to the nearest integer clocks, which is 144 at the defaults. Falling edges of two consecutive start bits are at least 10 bit periods (1440 clocks) apart.
- R3: While reset is asserted, `txd_o` is 1. After reset is released the line stays at 1 for at least 11 bit periods (1584 clocks) before the first start bit.
- R4: The banner bytes 0x52 0x45 0x41 0x44 0x59 0x20 0x76 0x31 0x0D 0x0A go out exactly once each, in this order. The first byte is never dropped and no byte is skipped or repeated.
- R5: The sequencer raises its write strobe only while the holding buffer is empty, and never on two clocks in a row. A byte waiting in the buffer is never overwritten before the shifter has taken it.
- R6: While `msg_en_i` is 0, no new byte is loaded. If it is 0 from reset, the line stays at 1 and `done_o` stays 0. Lowering it part way through stops transmission once at most the bytes already handed over are sent. Raising it again resumes with the next byte, with no skip or repeat.
- R7: `done_o` is 0 while a frame is in progress. It rises within 4 clocks after the last stop bit of the banner ends. From then on it stays 1 and the line stays at 1, whatever `msg_en_i` does.
- R8: `done_o` is 0 during reset. Each new reset sends the banner again from its first byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock (16.6 MHz nominal) |
| rst_ni | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| msg_en_i | input | 1 | Allows the sequencer to load banner bytes |
| txd_o | output | 1 | Serial line, 1 = mark / idle |
| done_o | output | 1 | Banner completely sent |

## Verification
A wrong character index or a lost strobe shows up on the decoded line within one frame (about 1440 clocks) as a missing, repeated or wrong byte. The first byte is the most exposed case. A bad baud count moves the stop-bit sample and the start-to-start spacing within the same frame. A short guard timer appears as a start bit before the 1584-clock mark. Premature done logic shows as `done_o` high while a frame is still on the line, or with fewer than ten bytes received. The bench runs a line decoder and an expected-byte queue against the pins on every clock. It covers start from reset, a delayed enable and a pause in mid-message.

// File: rtl/banner_pkg.sv
package banner_pkg;

  localparam int unsigned MSG_LEN = 10;
  localparam int unsigned IDX_W   = $clog2(MSG_LEN);

  typedef logic [IDX_W-1:0] idx_t;

  typedef enum logic [1:0] {
    TX_WARM = 2'd0,
    TX_IDLE = 2'd1,
    TX_SEND = 2'd2
  } tx_state_e;

  // Banner table: "READY v1" CR LF
  function automatic logic [7:0] banner_byte(input idx_t idx);
    logic [7:0] b;
    case (idx)
      idx_t'(0): b = 8'h52;
      idx_t'(1): b = 8'h45;
      idx_t'(2): b = 8'h41;
      idx_t'(3): b = 8'h44;
      idx_t'(4): b = 8'h59;
      idx_t'(5): b = 8'h20;
      idx_t'(6): b = 8'h76;
      idx_t'(7): b = 8'h31;
      idx_t'(8): b = 8'h0D;
      idx_t'(9): b = 8'h0A;
      default:   b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/banner_seq.sv
module banner_seq
  import banner_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       msg_en_i,
  input  logic       full_i,
  input  logic       tx_idle_i,
  output logic       wr_stb_o,
  output logic [7:0] wr_data_o,
  output logic       done_o
);

  localparam idx_t LAST_IDX = idx_t'(MSG_LEN - 1);

  idx_t       idx_q, idx_d;
  logic       stb_q, stb_d;
  logic       sent_q, sent_d;
  logic       done_q, done_d;
  logic [7:0] data_q, data_d;
  logic       load;

  always_comb begin
    load   = msg_en_i && !sent_q && !full_i && !stb_q;
    stb_d  = load;
    data_d = load ? banner_byte(idx_q) : data_q;
    sent_d = sent_q || (load && (idx_q == LAST_IDX));
    idx_d  = idx_q;
    if (stb_q && (idx_q != LAST_IDX)) begin
      idx_d = idx_q + idx_t'(1);
    end
    done_d = done_q || (sent_q && !stb_q && !full_i && tx_idle_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      stb_q  <= 1'b0;
      sent_q <= 1'b0;
      done_q <= 1'b0;
      data_q <= '0;
    end else begin
      idx_q  <= idx_d;
      stb_q  <= stb_d;
      sent_q <= sent_d;
      done_q <= done_d;
      data_q <= data_d;
    end
  end

  assign wr_stb_o  = stb_q;
  assign wr_data_o = data_q;
  assign done_o    = done_q;

  // R5
  one_write_per_two_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |=> !stb_q);
  // R5
  write_into_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |-> !full_i);
  // R7
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> done_q);

endmodule

// File: rtl/banner_hold.sv
module banner_hold (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_stb_i,
  input  logic [7:0] wr_data_i,
  input  logic       take_i,
  output logic       full_o,
  output logic [7:0] data_o
);

  logic       full_q, full_d;
  logic [7:0] data_q, data_d;
  logic       accept;

  always_comb begin
    accept = wr_stb_i && !full_q;
    data_d = accept ? wr_data_i : data_q;
    if (full_q) begin
      full_d = !take_i;
    end else begin
      full_d = wr_stb_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      data_q <= data_d;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;

  // R5
  no_overwrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && !take_i) |=> (data_q == $past(data_q)));

endmodule

// File: rtl/banner_serializer.sv
module banner_serializer
  import banner_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 16_600_000,
  parameter int unsigned BAUD      = 115_200,
  parameter int unsigned IDLE_BITS = 11
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       full_i,
  input  logic [7:0] data_i,
  output logic       take_o,
  output logic       idle_o,
  output logic       txd_o
);

  localparam int unsigned CPB        = (CLK_HZ + BAUD / 2) / BAUD;
  localparam int unsigned CNT_W      = $clog2(CPB);
  localparam int unsigned WARM_CYC   = IDLE_BITS * CPB;
  localparam int unsigned WARM_W     = $clog2(WARM_CYC);
  localparam int unsigned FRAME_BITS = 10;

  tx_state_e         st_q, st_d;
  logic [WARM_W-1:0] warm_q, warm_d;
  logic [CNT_W-1:0]  baud_q, baud_d;
  logic [3:0]        bit_q, bit_d;
  logic [8:0]        sh_q, sh_d;
  logic              txd_q, txd_d;
  logic              take;

  always_comb begin
    st_d   = st_q;
    warm_d = warm_q;
    baud_d = baud_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    txd_d  = txd_q;
    take   = 1'b0;
    unique case (st_q)
      TX_WARM: begin
        txd_d = 1'b1;
        if (warm_q == WARM_W'(WARM_CYC - 1)) begin
          st_d = TX_IDLE;
        end else begin
          warm_d = warm_q + WARM_W'(1);
        end
      end
      TX_IDLE: begin
        txd_d = 1'b1;
        if (full_i) begin
          take   = 1'b1;
          sh_d   = {1'b1, data_i};
          txd_d  = 1'b0;
          baud_d = '0;
          bit_d  = '0;
          st_d   = TX_SEND;
        end
      end
      TX_SEND: begin
        if (baud_q == CNT_W'(CPB - 1)) begin
          baud_d = '0;
          if (bit_q == 4'(FRAME_BITS - 1)) begin
            st_d  = TX_IDLE;
            txd_d = 1'b1;
          end else begin
            txd_d = sh_q[0];
            sh_d  = {1'b1, sh_q[8:1]};
            bit_d = bit_q + 4'd1;
          end
        end else begin
          baud_d = baud_q + CNT_W'(1);
        end
      end
      default: begin
        st_d  = TX_WARM;
        txd_d = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= TX_WARM;
      warm_q <= '0;
      baud_q <= '0;
      bit_q  <= '0;
      sh_q   <= '1;
      txd_q  <= 1'b1;
    end else begin
      st_q   <= st_d;
      warm_q <= warm_d;
      baud_q <= baud_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      txd_q  <= txd_d;
    end
  end

  assign take_o = take;
  assign idle_o = (st_q == TX_IDLE);
  assign txd_o  = txd_q;

  // R3
  warm_mark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == TX_WARM) |-> txd_q);
  // R1
  stop_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == TX_SEND) && (bit_q == 4'(FRAME_BITS - 1))) |-> txd_q);
  // R5
  take_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> !full_i);

endmodule

// File: rtl/banner_tx.sv
module banner_tx
  import banner_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 16_600_000,
  parameter int unsigned BAUD      = 115_200,
  parameter int unsigned IDLE_BITS = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic msg_en_i,
  output logic txd_o,
  output logic done_o
);

  logic       wr_stb;
  logic [7:0] wr_data;
  logic       full;
  logic [7:0] hold_data;
  logic       take;
  logic       tx_idle;

  banner_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .msg_en_i  (msg_en_i),
    .full_i    (full),
    .tx_idle_i (tx_idle),
    .wr_stb_o  (wr_stb),
    .wr_data_o (wr_data),
    .done_o    (done_o)
  );

  banner_hold u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_stb_i  (wr_stb),
    .wr_data_i (wr_data),
    .take_i    (take),
    .full_o    (full),
    .data_o    (hold_data)
  );

  banner_serializer #(
    .CLK_HZ    (CLK_HZ),
    .BAUD      (BAUD),
    .IDLE_BITS (IDLE_BITS)
  ) u_ser (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .full_i (full),
    .data_i (hold_data),
    .take_o (take),
    .idle_o (tx_idle),
    .txd_o  (txd_o)
  );

  // R7
  done_line_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> txd_o);

endmodule

// File: tb/banner_tx_test.sv
`timescale 1ns/1ps
module banner_tx_test;

  localparam int CPB   = 144;
  localparam int HALF  = CPB / 2;
  localparam int WARM  = 11 * CPB;
  localparam int FRAME = 10 * CPB;
  localparam int NMSG  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic msg_en = 1'b0;
  logic txd;
  logic done;

  always #2.5 clk = ~clk;

  banner_tx uut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .msg_en_i (msg_en),
    .txd_o    (txd),
    .done_o   (done)
  );

  int checks = 0;
  int errors = 0;
  byte unsigned exp_q[$];
  byte unsigned rx_q[$];

  int ncyc = 0;
  int since_rel = 0;
  int t = 0;
  int n_frames = 0;
  int last_start = 0;
  int last_end = 0;
  bit in_frame = 1'b0;
  logic [7:0] shv;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, ncyc);
    end
  endtask

  // Pin-level reference: line decoder and per-clock rules
  always @(negedge clk) begin
    ncyc++;
    if (!rst_n) begin
      since_rel = 0;
      in_frame  = 1'b0;
      n_frames  = 0;
      chk(txd === 1'b1, "R3 line high in reset", txd, 1);
      chk(done === 1'b0, "R8 done low in reset", done, 0);
    end else begin
      since_rel++;
      if (!in_frame) begin
        if (since_rel <= WARM) chk(txd === 1'b1, "R3 guard mark", txd, 1);
        if (done === 1'b1) chk(txd === 1'b1, "R7 idle after done", txd, 1);
        if (txd === 1'b0) begin
          in_frame = 1'b1;
          t = 0;
          shv = '0;
          if (n_frames == 0) chk(since_rel > WARM, "R3 first start time", since_rel, WARM + 1);
          else chk(ncyc - last_start >= FRAME, "R2 start spacing", ncyc - last_start, FRAME);
          last_start = ncyc;
          n_frames++;
        end
      end else begin
        t++;
        if (t == HALF) begin
          chk(txd === 1'b0, "R1 start bit", txd, 0);
          chk(done === 1'b0, "R7 done low in frame", done, 0);
        end
        if (t == CPB - 1) chk(txd === 1'b0, "R2 start width", txd, 0);
        if (t >= CPB && t < 9 * CPB && ((t - CPB) % CPB) == HALF)
          shv[(t - CPB) / CPB] = txd;
        if (t == 9 * CPB + HALF) chk(txd === 1'b1, "R1 stop bit", txd, 1);
        if (t == FRAME - 1) begin
          chk(txd === 1'b1, "R2 stop width", txd, 1);
          rx_q.push_back(shv);
          in_frame = 1'b0;
          last_end = ncyc;
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic en);
    @(posedge clk); #1;
    rst_n = 1'b0;
    msg_en = en;
    step(5);
    rx_q.delete();
    rst_n = 1'b1;
  endtask

  task automatic wait_done(input int limit);
    int n = 0;
    while (done !== 1'b1 && n < limit) begin
      step(1);
      n++;
    end
    chk(done === 1'b1, "R7 done reached", done, 1);
    chk(!in_frame, "R7 no frame at done", in_frame, 0);
    chk(ncyc - last_end <= 4, "R7 done latency", ncyc - last_end, 4);
  endtask

  task automatic compare_msg(input string req);
    chk(rx_q.size() == NMSG, {req, " byte count"}, rx_q.size(), NMSG);
    for (int i = 0; i < NMSG; i++) begin
      if (i < rx_q.size()) chk(rx_q[i] == exp_q[i], {req, " byte value"}, rx_q[i], exp_q[i]);
    end
  endtask

  initial begin
    string s;
    int held;
    s = "READY v1";
    for (int i = 0; i < s.len(); i++) exp_q.push_back(s[i]);
    exp_q.push_back(8'h0D);
    exp_q.push_back(8'h0A);

    // Run 1: enable from reset (R1 R2 R3 R4 R7)
    do_reset(1'b1);
    wait_done(30000);
    compare_msg("R4 run1");
    held = rx_q.size();
    msg_en = 1'b0; step(500);
    msg_en = 1'b1; step(2500);
    chk(rx_q.size() == held, "R7 no resend after done", rx_q.size(), held);
    chk(done === 1'b1, "R7 done held", done, 1);

    // Run 2: enable held low, then raised (R6 R8)
    do_reset(1'b0);
    step(5000);
    chk(rx_q.size() == 0, "R6 nothing sent while disabled", rx_q.size(), 0);
    chk(done === 1'b0, "R6 done low while disabled", done, 0);
    chk(txd === 1'b1, "R6 line idle while disabled", txd, 1);
    msg_en = 1'b1;
    wait_done(30000);
    compare_msg("R8 run2 restart");

    // Run 3: pause mid-message (R6)
    do_reset(1'b1);
    while (rx_q.size() < 3) step(1);
    msg_en = 1'b0;
    step(5000);
    held = rx_q.size();
    chk(held <= 5, "R6 bounded drain on pause", held, 5);
    step(3000);
    chk(rx_q.size() == held, "R6 paused line quiet", rx_q.size(), held);
    chk(done === 1'b0, "R6 done low while paused", done, 0);
    msg_en = 1'b1;
    wait_done(30000);
    compare_msg("R6 run3 resume");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 180000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule